// File: doc/BRIEF.md
# Per-CPU Interrupt Wakeup Generator

This block sits in an always-on domain next to a main interrupt controller. It receives a vector of shared peripheral interrupt lines (128 by default) and hands every line unchanged to the downstream controller. It also keeps, for each CPU (two by default), a set of 32-bit enable words with one bit per interrupt. From these it derives a registered wakeup request per CPU that is raised whenever at least one interrupt that CPU has enabled is active.

Software reaches the enable words through a small word-addressed register port. Each CPU's words occupy a window starting at `cpu * 0x400`, and word `k` of a window sits at byte offset `4*k`. Interrupt `n` is controlled by word `n >> 5`, bit `n % 32`. Interrupt levels are brought into the clock domain through a two-flop synchronizer before the wakeup logic sees them.

Top module: `irq_wake_gen`

## Requirements
- R1: After reset every enable bit is 0, every register read returns 0 and both wakeup outputs are 0 for any interrupt input.
- R2: `irq_out` equals `irq_in` at all times, combinationally, whatever the enable bits hold.
- R3: A write with `reg_wr` high to byte address `c*0x400 + 4*k` (c below the CPU count, k below 4) stores `reg_wdata` into enable word k of CPU c at the next clock edge; a read with `reg_rd` high to that address presents the stored word on `reg_rdata` after the next clock edge.
- R4: Interrupt n is enabled for CPU c by bit `n % 32` of word `n >> 5` of that CPU; `wake_req[c]` (bit c) depends only on CPU c's enables.
- R5: A rising interrupt level that is enabled raises `wake_req[c]` on the third clock edge after the input changes, not earlier (two synchronizer stages plus the output register).
- R6: Reads of any address that is misaligned (low two bits nonzero), has a word index of 4 or more inside a window, or names a CPU number of 2 or more return 0; writes to such addresses change no enable bit.
- R7: Writing all ones to a word enables all 32 interrupts of that word for that CPU.
- R8: Writing 0 to a word masks its interrupts: `wake_req[c]` falls on the clock edge after the edge that stored the write, even while the interrupt stays high.
- R9: When the enabled interrupt goes low, `wake_req[c]` falls on the third clock edge after the change.
- R10: For any mix of enable words and active lines, `wake_req[c]` equals the OR over all lines of (synchronized line AND CPU c's enable bit).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_in | input | 128 | Level-sensitive interrupt lines from peripherals |
| irq_out | output | 128 | Unchanged copy of the interrupt lines for the downstream controller |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 12 | Byte address of the access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid after the edge that sampled `reg_rd` |
| wake_req | output | 2 | Registered wakeup request, bit c for CPU c |

## Verification
Read data is due one edge after the strobe, so the driver queues the expected word when it raises `reg_rd` and the monitor compares it at the falling edge after that rising edge. A change on an interrupt line reaches `wake_req` on the third rising edge, and an enable write reaches it on the edge after the one that stores it; the bench samples one edge early to prove nothing arrives too soon and then on the due edge. The passthrough is compared a short delay after each input change, with no clock edge in between.

// File: rtl/wkg_pkg.sv
package wkg_pkg;

  // CPU number selected by a byte address
  function automatic int unsigned addr_cpu(input int unsigned a, input int unsigned stride);
    return a / stride;
  endfunction

  // Word index inside a CPU window
  function automatic int unsigned addr_word(input int unsigned a, input int unsigned stride);
    return (a % stride) >> 2;
  endfunction

  // True when the address names an existing, aligned enable word
  function automatic logic addr_hit(input int unsigned a, input int unsigned stride,
                                    input int unsigned ncpu, input int unsigned nword);
    return ((a & 3) == 0) && (addr_cpu(a, stride) < ncpu) && (addr_word(a, stride) < nword);
  endfunction

  // Enable word holding interrupt n
  function automatic int unsigned irq_word(input int unsigned n, input int unsigned width);
    return n / width;
  endfunction

  // Bit position of interrupt n inside its word
  function automatic int unsigned irq_bit(input int unsigned n, input int unsigned width);
    return n % width;
  endfunction

endpackage

// File: rtl/wkg_sync.sv
module wkg_sync #(
  parameter int WIDTH = 128,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[0] <= '0;
          else        stage_q[0] <= d;
        end
      end else begin : g_rest
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[s] <= '0;
          else        stage_q[s] <= stage_q[s-1];
        end
      end
    end
  endgenerate

  assign q = stage_q[STAGES-1];

endmodule

// File: rtl/wkg_enable_bank.sv
module wkg_enable_bank #(
  parameter int NUM_IRQ = 128,
  parameter int WORD    = 32,
  localparam int NWORD  = (NUM_IRQ + WORD - 1) / WORD,
  localparam int IDX_W  = (NWORD > 1) ? $clog2(NWORD) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] idx,
  input  logic [WORD-1:0]  wdata,
  output logic [WORD-1:0]  rword,
  output logic [NUM_IRQ-1:0] en
);

  logic [WORD-1:0]       word_q [NWORD];
  logic [NWORD*WORD-1:0] flat;

  generate
    for (genvar k = 0; k < NWORD; k++) begin : g_word
      logic sel;
      assign sel = wr_en && (32'(idx) == k);
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   word_q[k] <= '0;
        else if (sel) word_q[k] <= wdata;
      end
      assign flat[k*WORD +: WORD] = word_q[k];
    end
  endgenerate

  always_comb begin
    rword = '0;
    for (int k = 0; k < NWORD; k++) begin
      if (32'(idx) == k) rword = word_q[k];
    end
  end

  assign en = flat[NUM_IRQ-1:0];

endmodule

// File: rtl/wkg_wake_or.sv
module wkg_wake_or #(
  parameter int NUM_IRQ = 128
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_IRQ-1:0] irq_s,
  input  logic [NUM_IRQ-1:0] en,
  output logic               match_any,
  output logic               wake
);

  assign match_any = |(irq_s & en);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wake <= 1'b0;
    else        wake <= match_any;
  end

endmodule

// File: rtl/irq_wake_gen.sv
module irq_wake_gen #(
  parameter int NUM_IRQ = 128,
  parameter int NUM_CPU = 2,
  parameter int WORD    = 32,
  parameter int STRIDE  = 'h400,
  parameter int ADDR_W  = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_IRQ-1:0] irq_in,
  output logic [NUM_IRQ-1:0] irq_out,
  input  logic               reg_wr,
  input  logic               reg_rd,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [WORD-1:0]    reg_wdata,
  output logic [WORD-1:0]    reg_rdata,
  output logic [NUM_CPU-1:0] wake_req
);

  localparam int NWORD = (NUM_IRQ + WORD - 1) / WORD;
  localparam int IDX_W = (NWORD > 1) ? $clog2(NWORD) : 1;
  localparam int CPU_W = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1;

  // Named internal events, observed by the checker
  logic                       acc_hit;
  logic [CPU_W-1:0]           acc_cpu;
  logic [IDX_W-1:0]           acc_word;
  logic [NUM_CPU-1:0]         wr_sel;
  logic [WORD-1:0]            bank_word [NUM_CPU];
  logic [NUM_CPU*NUM_IRQ-1:0] en_flat;
  logic [NUM_IRQ-1:0]         irq_sync;
  logic [NUM_CPU-1:0]         match_any;
  logic [WORD-1:0]            rd_mux;
  logic [WORD-1:0]            rdata_q;

  // Passthrough to the downstream controller
  assign irq_out = irq_in;

  // Address decode
  assign acc_hit  = wkg_pkg::addr_hit(32'(reg_addr), STRIDE, NUM_CPU, NWORD);
  assign acc_cpu  = CPU_W'(wkg_pkg::addr_cpu(32'(reg_addr), STRIDE));
  assign acc_word = IDX_W'(wkg_pkg::addr_word(32'(reg_addr), STRIDE));

  wkg_sync #(.WIDTH(NUM_IRQ), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (irq_in),
    .q     (irq_sync)
  );

  generate
    for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
      logic [NUM_IRQ-1:0] en_c;

      assign wr_sel[c] = reg_wr && acc_hit && (32'(acc_cpu) == c);

      wkg_enable_bank #(.NUM_IRQ(NUM_IRQ), .WORD(WORD)) u_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (wr_sel[c]),
        .idx   (acc_word),
        .wdata (reg_wdata),
        .rword (bank_word[c]),
        .en    (en_c)
      );

      assign en_flat[c*NUM_IRQ +: NUM_IRQ] = en_c;

      wkg_wake_or #(.NUM_IRQ(NUM_IRQ)) u_wake (
        .clk       (clk),
        .rst_n     (rst_n),
        .irq_s     (irq_sync),
        .en        (en_c),
        .match_any (match_any[c]),
        .wake      (wake_req[c])
      );
    end
  endgenerate

  // Read path
  always_comb begin
    rd_mux = '0;
    for (int c = 0; c < NUM_CPU; c++) begin
      if (acc_hit && (32'(acc_cpu) == c)) rd_mux = bank_word[c];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdata_q <= '0;
    else if (reg_rd) rdata_q <= rd_mux;
  end

  assign reg_rdata = rdata_q;

endmodule

// File: rtl/wkg_checker.sv
module wkg_checker #(
  parameter int NUM_IRQ = 128,
  parameter int NUM_CPU = 2,
  parameter int WORD    = 32,
  parameter int SYNC_STAGES = 2,
  localparam int NWORD  = (NUM_IRQ + WORD - 1) / WORD,
  localparam int IDX_W  = (NWORD > 1) ? $clog2(NWORD) : 1,
  localparam int CPU_W  = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       reg_wr,
  input logic                       reg_rd,
  input logic [WORD-1:0]            reg_wdata,
  input logic [WORD-1:0]            reg_rdata,
  input logic                       acc_hit,
  input logic [CPU_W-1:0]           acc_cpu,
  input logic [IDX_W-1:0]           acc_word,
  input logic [NUM_CPU*NUM_IRQ-1:0] en_flat,
  input logic [NUM_IRQ-1:0]         irq_in,
  input logic [NUM_IRQ-1:0]         irq_sync,
  input logic [NUM_CPU-1:0]         wake_req
);

  logic [1:0]      age_q;
  logic            wr_q;
  int unsigned     wr_base_q;
  logic [WORD-1:0] wdata_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      age_q     <= '0;
      wr_q      <= 1'b0;
      wr_base_q <= '0;
      wdata_q   <= '0;
    end else begin
      if (age_q != 2'd3) age_q <= age_q + 2'd1;
      wr_q      <= reg_wr && acc_hit;
      wr_base_q <= 32'(acc_cpu) * NUM_IRQ + 32'(acc_word) * WORD;
      wdata_q   <= reg_wdata;
    end
  end

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_q |-> en_flat[wr_base_q +: WORD] == wdata_q); // R3

  AST_UNMAPPED_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !acc_hit) |=> $stable(en_flat)); // R6

  AST_UNMAPPED_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && !acc_hit) |=> reg_rdata == '0); // R6

  AST_SYNC_DEPTH: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q >= 2'(SYNC_STAGES)) |-> irq_sync == $past(irq_in, 2)); // R5

  generate
    for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu_chk
      AST_MASKED_NO_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
        (en_flat[c*NUM_IRQ +: NUM_IRQ] == '0) |=> !wake_req[c]); // R4
      AST_IDLE_NO_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_sync == '0) |=> !wake_req[c]); // R10
    end
  endgenerate

endmodule

bind irq_wake_gen wkg_checker #(
  .NUM_IRQ(NUM_IRQ), .NUM_CPU(NUM_CPU), .WORD(WORD), .SYNC_STAGES(SYNC_STAGES)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_wr    (reg_wr),
  .reg_rd    (reg_rd),
  .reg_wdata (reg_wdata),
  .reg_rdata (reg_rdata),
  .acc_hit   (acc_hit),
  .acc_cpu   (acc_cpu),
  .acc_word  (acc_word),
  .en_flat   (en_flat),
  .irq_in    (irq_in),
  .irq_sync  (irq_sync),
  .wake_req  (wake_req)
);

// File: tb/tb_irq_wake_gen.sv
module tb_irq_wake_gen;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [127:0] irq_in = '0;
  logic [127:0] irq_out;
  logic         reg_wr = 1'b0;
  logic         reg_rd = 1'b0;
  logic [11:0]  reg_addr = '0;
  logic [31:0]  reg_wdata = '0;
  logic [31:0]  reg_rdata;
  logic [1:0]   wake_req;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  logic [31:0] model [2][4];

  typedef struct {
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t sb_q[$];

  always #10 clk = ~clk;

  irq_wake_gen dut (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .irq_out(irq_out),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .wake_req(wake_req)
  );

  task automatic check(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    if (a[1:0] == 2'b00 && a[11] == 1'b0 && a[9:4] == 6'd0)
      model[a[10]][a[3:2]] = d;
    tick(1);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, input string tag);
    item_t it;
    it.tag = tag;
    if (a[1:0] == 2'b00 && a[11] == 1'b0 && a[9:4] == 6'd0)
      it.exp = model[a[10]][a[3:2]];
    else
      it.exp = '0;
    sb_q.push_back(it);
    reg_rd = 1'b1; reg_addr = a;
    tick(1);
    reg_rd = 1'b0;
  endtask

  // Monitor: pops one expected word per read strobe
  initial begin
    forever begin
      @(posedge clk);
      if (reg_rd) begin
        @(negedge clk);
        if (sb_q.size() == 0) begin
          check(1'b0, "scoreboard underflow", 0, 0);
        end else begin
          item_t it;
          it = sb_q.pop_front();
          check(reg_rdata === it.exp, it.tag, reg_rdata, it.exp);
        end
      end
    end
  end

  function automatic logic [1:0] exp_wake(input logic [127:0] v);
    logic [1:0] r;
    for (int c = 0; c < 2; c++) begin
      logic [127:0] m;
      m = {model[c][3], model[c][2], model[c][1], model[c][0]};
      r[c] = |(v & m);
    end
    return r;
  endfunction

  task automatic read_all(input string tag);
    for (int c = 0; c < 2; c++)
      for (int k = 0; k < 4; k++)
        rd(12'(c * 'h400 + k * 4), tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    for (int c = 0; c < 2; c++)
      for (int k = 0; k < 4; k++)
        model[c][k] = '0;
    irq_in = {4{32'hFFFF_FFFF}};
    tick(3);
    check(wake_req === 2'b00, "R1 wake low in reset", wake_req, 0);
    rst_n = 1'b1;
    tick(4);
    check(wake_req === 2'b00, "R1 wake low with all enables cleared", wake_req, 0);
    read_all("R1 reset value");

    // R2 passthrough
    irq_in = {32'hDEAD_BEEF, 32'h0123_4567, 32'h89AB_CDEF, 32'h5555_AAAA};
    #1 check(irq_out === irq_in, "R2 passthrough", irq_out, irq_in);
    irq_in = '0;
    #1 check(irq_out === irq_in, "R2 passthrough zero", irq_out, irq_in);
    tick(3);

    // R3 write then read every word
    for (int c = 0; c < 2; c++)
      for (int k = 0; k < 4; k++)
        wr(12'(c * 'h400 + k * 4), 32'hA500_0000 ^ 32'(c << 8) ^ (32'h1111_1111 * (k + 1)));
    read_all("R3 readback");
    for (int c = 0; c < 2; c++)
      for (int k = 0; k < 4; k++)
        wr(12'(c * 'h400 + k * 4), 32'h0);
    read_all("R3 cleared");

    // R4 interrupt 37 on CPU1 -> word 1 bit 5; R5 latency
    wr(12'h404, 32'h0000_0020);
    irq_in[37] = 1'b1;
    #1 check(irq_out === irq_in, "R2 passthrough single", irq_out, irq_in);
    tick(2);
    check(wake_req === 2'b00, "R5 wake not before third edge", wake_req, 0);
    tick(1);
    check(wake_req === 2'b10, "R4 R5 cpu1 wake only", wake_req, 2'b10);
    // R9 deassert
    irq_in[37] = 1'b0;
    tick(2);
    check(wake_req === 2'b10, "R9 wake held two edges", wake_req, 2'b10);
    tick(1);
    check(wake_req === 2'b00, "R9 wake falls on third edge", wake_req, 0);
    // R4 neighbour bit does not match
    irq_in[36] = 1'b1;
    tick(3);
    check(wake_req === 2'b00, "R4 neighbour bit masked", wake_req, 0);
    irq_in = '0;
    wr(12'h404, 32'h0);

    // R7 all ones on CPU0 word 3
    wr(12'h00C, 32'hFFFF_FFFF);
    irq_in[127] = 1'b1;
    tick(3);
    check(wake_req === 2'b01, "R7 all ones enables line 127", wake_req, 2'b01);
    irq_in[127] = 1'b0; irq_in[96] = 1'b1;
    tick(3);
    check(wake_req === 2'b01, "R7 all ones enables line 96", wake_req, 2'b01);

    // R8 mask while active
    wr(12'h00C, 32'h0);
    check(wake_req === 2'b01, "R8 wake before mask takes effect", wake_req, 2'b01);
    tick(1);
    check(wake_req === 2'b00, "R8 wake falls after mask", wake_req, 0);
    irq_in = '0;
    tick(3);

    // R6 unmapped accesses
    wr(12'h400, 32'h0000_0001);
    wr(12'h010, 32'hFFFF_FFFF);
    wr(12'h401, 32'hFFFF_FFFF);
    wr(12'h800, 32'hFFFF_FFFF);
    wr(12'h7FC, 32'hFFFF_FFFF);
    read_all("R6 writes to unmapped ignored");
    rd(12'h401, "R6 misaligned read zero");
    rd(12'h010, "R6 word index 4 read zero");
    rd(12'h800, "R6 cpu 2 read zero");
    irq_in = {4{32'hFFFF_FFFF}};
    tick(3);
    check(wake_req === 2'b10, "R6 unmapped writes did not enable", wake_req, 2'b10);
    irq_in = '0;

    // R10 mixed patterns
    for (int it = 0; it < 20; it++) begin
      for (int c = 0; c < 2; c++)
        for (int k = 0; k < 4; k++)
          wr(12'(c * 'h400 + k * 4), $urandom() & $urandom() & $urandom());
      irq_in = {$urandom(), $urandom(), $urandom(), $urandom()} &
               {$urandom(), $urandom(), $urandom(), $urandom()};
      tick(3);
      check(wake_req === exp_wake(irq_in), "R10 mixed pattern", wake_req, exp_wake(irq_in));
    end
    read_all("R3 final readback");
    tick(2);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule